// File: doc/BRIEF.md
# Multi-Harmonic Phase-Accumulator Waveform Synthesizer

The block builds one digital waveform out of a fundamental tone and up to four harmonics of it. Each component has a 32-bit phase accumulator. The accumulator for component h steps by h times the shared frequency word on every enabled clock. The top ten bits of each accumulator, plus that component's own phase offset, address a sine lookup. The lookup stores only the first quarter of a period. The other three quarters are rebuilt by mirroring the table index and negating the result.

Each component's signed sample is scaled by its own unsigned weight. The scaled samples are summed and then clipped to a 16-bit signed output. All controls can be changed while the block runs. A change to the frequency word never resets phase, so the waveform stays continuous. The output feeds an external converter and filter.

Top module: `harm_dds_gen`

## Requirements
- R1: On each clock edge where `en_i` is 1, the accumulator of component c (c = 0 is the fundamental, at slice c of every packed input) adds (c+1)·`fcw_i` modulo 2^32. All accumulators start from zero.
- R2: On an edge where `en_i` is 0, every accumulator keeps its value. When enabling resumes, phase continues from the held value.
- R3: A new `fcw_i` is used from the first enabled edge at which it is present. The accumulators are not cleared, so phase stays continuous across the change.
- R4: The lookup address of component c is accumulator bits [31:22] plus `phase_off_i[10c+9:10c]`, modulo 1024. If address bit 8 is set, the low 8 bits are inverted before the lookup. If address bit 9 is set, the looked-up magnitude is negated.
- R5: Quarter table entry i (0..255) holds round(4095·sin(π·(2i+1)/1024)) as a 12-bit unsigned magnitude. The table is computed in the RTL.
- R6: Component c contributes its signed sample times the unsigned 8-bit `weight_i[8c+7:8c]`. A weight of zero removes that component from the output.
- R7: The sum of all weighted components is clipped to the range −32768 to 32767 before it drives `sample_o`.
- R8: If `en_i` is 1 at edge t, `valid_o` is 1 after edge t+3. `sample_o` then carries the sample for the accumulator state produced at edge t. When `en_i` is 0 at edge t, `valid_o` is 0 after t+3.
- R9: Reset (`rst_ni` = 0) clears all accumulators and pipeline registers, so `sample_o` = 0 and `valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the accumulators and emit one sample |
| fcw_i | input | 32 | Frequency word of the fundamental |
| phase_off_i | input | 50 | Five 10-bit phase offsets, component c at bits [10c+9:10c] |
| weight_i | input | 40 | Five 8-bit unsigned weights, component c at bits [8c+7:8c] |
| sample_o | output | 16 | Saturated signed output sample |
| valid_o | output | 1 | `sample_o` holds a new sample |

## Verification
The two functions that can fall in the same cycle are a frequency-word change and the return of enable after a hold. The bench stops enabling for several cycles and then raises `en_i` on the same edge that presents a new `fcw_i`. A reference model of the five accumulators must show that phase resumes from the held value and steps by the new word at once. Every emitted sample is compared against the model through a queue, and the timing of `valid_o` is compared each cycle against the bench's own record of `en_i`.

// File: rtl/harm_dds_pkg.sv
package harm_dds_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned OFF_W  = ADDR_W;
  localparam int unsigned MAG_W  = 12;
  localparam int unsigned WGT_W  = 8;
  localparam int unsigned OUT_W  = 16;
  localparam int unsigned QIDX_W = ADDR_W - 2;
  localparam int unsigned QDEPTH = 1 << QIDX_W;
  localparam int unsigned SMP_W  = MAG_W + 1;
  localparam int unsigned PROD_W = SMP_W + WGT_W + 1;
  localparam int unsigned PIPE_D = 3;

  // magnitude at the centre of quarter-wave bin idx
  function automatic logic [MAG_W-1:0] qsin_mag(input int idx);
    real ang;
    real val;
    ang = 3.14159265358979 * real'(2 * idx + 1) / real'(4 * QDEPTH);
    val = real'((1 << MAG_W) - 1) * $sin(ang) + 0.5;
    return MAG_W'($rtoi(val));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import harm_dds_pkg::*;
#(
  parameter int unsigned MULT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] fcw_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] inc;
  assign inc = fcw_i * ACC_W'(MULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= acc_o + inc;
  end

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o)); // R2
endmodule

// File: rtl/dds_quarter_sine.sv
module dds_quarter_sine
  import harm_dds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SMP_W-1:0]  samp_o
);
  logic [MAG_W-1:0]  rom [QDEPTH];
  logic [QIDX_W-1:0] idx;
  logic [SMP_W-1:0]  mag_ext;
  logic              seen_q;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
    localparam logic [MAG_W-1:0] ENTRY = qsin_mag(i);
    assign rom[i] = ENTRY;
  end

  // second and fourth quadrants read the table backwards
  assign idx     = addr_i[ADDR_W-2] ? ~addr_i[QIDX_W-1:0] : addr_i[QIDX_W-1:0];
  assign mag_ext = {1'b0, rom[idx]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      seen_q <= 1'b0;
    end else begin
      samp_o <= addr_i[ADDR_W-1] ? (~mag_ext + 1'b1) : mag_ext;
      seen_q <= 1'b1;
    end
  end

  AST_LOWER_HALF_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(addr_i[ADDR_W-1])) |-> samp_o[SMP_W-1]); // R4
  AST_UPPER_HALF_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(addr_i[ADDR_W-1])) |-> !samp_o[SMP_W-1]); // R4
endmodule

// File: rtl/dds_weight_mix.sv
module dds_weight_mix
  import harm_dds_pkg::*;
#(
  parameter int unsigned NUM_COMP = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_COMP*SMP_W-1:0] samp_i,
  input  logic [NUM_COMP*WGT_W-1:0] wgt_i,
  output logic [OUT_W-1:0]          sum_o
);
  localparam int unsigned SUM_W = PROD_W + $clog2(NUM_COMP + 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - 1;

  logic signed [PROD_W-1:0] prod_d [NUM_COMP];
  logic signed [PROD_W-1:0] prod_q [NUM_COMP];
  logic signed [SUM_W-1:0]  sum_d;
  logic [OUT_W-1:0]         sat_d;

  always_comb begin
    for (int c = 0; c < NUM_COMP; c++) begin
      prod_d[c] = PROD_W'($signed(samp_i[c*SMP_W +: SMP_W]))
                * PROD_W'($signed({1'b0, wgt_i[c*WGT_W +: WGT_W]}));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_COMP; c++) prod_q[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_COMP; c++) prod_q[c] <= prod_d[c];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int c = 0; c < NUM_COMP; c++) sum_d = sum_d + SUM_W'(prod_q[c]);
  end

  always_comb begin
    if (sum_d > MAXV)      sat_d = MAXV[OUT_W-1:0];
    else if (sum_d < MINV) sat_d = MINV[OUT_W-1:0];
    else                   sat_d = sum_d[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sat_d;
  end

  // weights enter at the product stage, two registers before sum_o
  AST_ZERO_WEIGHT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wgt_i == '0) |-> ##2 (sum_o == '0)); // R6
endmodule

// File: rtl/harm_dds_gen.sv
module harm_dds_gen
  import harm_dds_pkg::*;
#(
  parameter int unsigned NUM_COMP = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [ACC_W-1:0]          fcw_i,
  input  logic [NUM_COMP*OFF_W-1:0] phase_off_i,
  input  logic [NUM_COMP*WGT_W-1:0] weight_i,
  output logic [OUT_W-1:0]          sample_o,
  output logic                      valid_o
);
  logic [NUM_COMP*SMP_W-1:0] samp_flat;
  logic [PIPE_D:0]           vld_q;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [ACC_W-1:0]  acc;
    logic [ADDR_W-1:0] addr;

    dds_phase_acc #(.MULT(c + 1)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .fcw_i (fcw_i),
      .acc_o (acc)
    );

    assign addr = acc[ACC_W-1 -: ADDR_W] + phase_off_i[c*OFF_W +: OFF_W];

    dds_quarter_sine u_sine (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .addr_i(addr),
      .samp_o(samp_flat[c*SMP_W +: SMP_W])
    );
  end

  dds_weight_mix #(.NUM_COMP(NUM_COMP)) u_mix (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .samp_i(samp_flat),
    .wgt_i (weight_i),
    .sum_o (sample_o)
  );

  // one stage runs alongside the accumulators, three follow them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PIPE_D-1:0], en_i};
  end
  assign valid_o = vld_q[PIPE_D];

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ##4 valid_o); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ##4 !valid_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (sample_o == '0 && !valid_o)); // R9
endmodule

// File: tb/harm_dds_gen_tb_top.sv
module harm_dds_gen_tb_top;
  localparam int NC = 5;
  localparam real PI = 3.14159265358979;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            en_i;
  logic [31:0]     fcw_i;
  logic [NC*10-1:0] phase_off_i;
  logic [NC*8-1:0]  weight_i;
  logic [15:0]     sample_o;
  logic            valid_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] macc [NC];
  int          offs [NC];
  int          wts  [NC];
  int          exp_q [$];
  string       tag_q [$];
  logic [3:0]  vhist = '0;

  always #4 clk_i = ~clk_i;

  harm_dds_gen #(.NUM_COMP(NC)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .fcw_i      (fcw_i),
    .phase_off_i(phase_off_i),
    .weight_i   (weight_i),
    .sample_o   (sample_o),
    .valid_o    (valid_o)
  );

  function automatic int ref_sample();
    int s;
    s = 0;
    for (int h = 0; h < NC; h++) begin
      logic [9:0] a;
      logic [7:0] ix;
      int m;
      a  = macc[h][31:22] + 10'(offs[h]);
      ix = a[8] ? ~a[7:0] : a[7:0];
      m  = $rtoi(4095.0 * $sin(PI * (2.0 * real'(ix) + 1.0) / 1024.0) + 0.5);
      if (a[9]) m = -m;
      s += m * wts[h];
    end
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk_i) vhist <= {vhist[2:0], en_i};

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      check(valid_o === vhist[3], "R8 valid timing", int'(valid_o), int'(vhist[3]));
      if (valid_o === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected sample", int'($signed(sample_o)), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'($signed(sample_o)) == e, t, int'($signed(sample_o)), e);
        end
      end
    end
  end

  task automatic tick(input bit en, input logic [31:0] k, input string tag);
    @(negedge clk_i);
    en_i  = en;
    fcw_i = k;
    @(posedge clk_i);
    if (en) begin
      for (int h = 0; h < NC; h++) macc[h] = macc[h] + k * 32'(h + 1);
      exp_q.push_back(ref_sample());
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) tick(1'b0, fcw_i, "idle");
  endtask

  task automatic set_cfg(input int o0, input int o1, input int o2, input int o3, input int o4,
                         input int w0, input int w1, input int w2, input int w3, input int w4);
    drain();
    @(negedge clk_i);
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3; offs[4] = o4;
    wts[0]  = w0; wts[1]  = w1; wts[2]  = w2; wts[3]  = w3; wts[4]  = w4;
    for (int h = 0; h < NC; h++) begin
      phase_off_i[h*10 +: 10] = 10'(offs[h]);
      weight_i[h*8 +: 8]      = 8'(wts[h]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b0;
    for (int h = 0; h < NC; h++) macc[h] = '0;
    repeat (2) @(negedge clk_i);
    check(sample_o == 16'd0, "R9 sample in reset", int'(sample_o), 0);
    check(valid_o == 1'b0, "R9 valid in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int plist [10];
    rst_ni = 1'b0;
    en_i = 1'b0;
    fcw_i = '0;
    phase_off_i = '0;
    weight_i = '0;
    for (int h = 0; h < NC; h++) begin
      macc[h] = '0;
      offs[h] = 0;
      wts[h]  = 0;
    end
    repeat (3) @(negedge clk_i);
    check(sample_o == 16'd0, "R9 initial sample", int'(sample_o), 0);
    check(valid_o == 1'b0, "R9 initial valid", int'(valid_o), 0);
    rst_ni = 1'b1;

    // R5 / R4: frozen accumulators, offset alone picks the table point
    plist = '{0, 255, 256, 511, 512, 767, 768, 1023, 100, 700};
    foreach (plist[i]) begin
      set_cfg(plist[i], 0, 0, 0, 0, 1, 0, 0, 0, 0);
      tick(1'b1, 32'd0, "R5 table point");
    end
    set_cfg(0, 0, 900, 0, 0, 0, 0, 1, 0, 0);
    tick(1'b1, 32'd0, "R4 mirrored negative quadrant");
    set_cfg(0, 0, 0, 300, 0, 0, 0, 0, 1, 0);
    tick(1'b1, 32'd0, "R4 mirrored positive quadrant");

    // R1: all components running
    set_cfg(0, 100, 300, 600, 900, 6, 3, 2, 1, 1);
    for (int i = 0; i < 40; i++) tick(1'b1, 32'h0123_4567, "R1 harmonic sum");

    // R3: word change mid-run, phase continues
    for (int i = 0; i < 30; i++) tick(1'b1, 32'h0A3D_70A4, "R3 new word");

    // R2: hold, then resume on the same edge as another word change
    for (int i = 0; i < 6; i++) tick(1'b0, 32'h0A3D_70A4, "R2 hold");
    for (int i = 0; i < 20; i++) tick(1'b1, 32'h0333_3333, "R2 R3 resume with new word");
    for (int i = 0; i < 10; i++) tick(i % 3 != 0, 32'h0333_3333, "R2 gapped enable");

    // R6: single weighted harmonic
    set_cfg(0, 100, 300, 600, 900, 0, 0, 9, 0, 0);
    for (int i = 0; i < 20; i++) tick(1'b1, 32'h0200_0000, "R6 lone harmonic");

    // R9: reset clears accumulators; R7 saturation both ways
    drain();
    do_reset();
    set_cfg(256, 256, 256, 256, 256, 255, 255, 255, 255, 255);
    tick(1'b1, 32'd0, "R7 positive clip");
    tick(1'b1, 32'd0, "R9 accumulators cleared");
    set_cfg(768, 768, 768, 768, 768, 255, 255, 255, 255, 255);
    tick(1'b1, 32'd0, "R7 negative clip");
    set_cfg(256, 768, 256, 768, 256, 255, 255, 255, 255, 255);
    tick(1'b1, 32'd0, "R7 mixed clip");
    set_cfg(0, 0, 0, 0, 0, 255, 200, 150, 100, 50);
    for (int i = 0; i < 30; i++) tick(1'b1, 32'h0100_0000, "R7 running clip");

    drain();
    check(exp_q.size() == 0, "R8 samples outstanding", exp_q.size(), 0);
    check(-32768 < 0, "R7 sanity", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule